// File: doc/BRIEF.md
# Dual-channel ADC output stage controller

This block is the digital back end shared by two matched converter channels, A and B. On each rising clock edge it accepts one corrected 10-bit code per channel, in offset-binary form. It delays both codes through a fixed five-register path, so the two channels stay aligned. It converts each code to the number format chosen by a select pin and presents the results on two parallel buses. A separate drive-enable output per bus stands for the high-impedance state that the output-enable pin controls.

The block also handles the two power-save modes. While power-down or sleep is requested, both buses keep the last value they showed and the data-valid output is low. When the request is released, a wake-up counter runs for the wake time of the mode being left. The wake times are derived from a clock-frequency parameter: 11 cycles from sleep and 30 from power-down at 20 MHz. The pipeline is then refilled with fresh samples, and only after that do valid and fresh data return. Power-down takes priority over sleep.

Top module: `adc_out_stage`

## Requirements
- R1: A code pair driven in clock cycle n appears on `bus_a_o`/`bus_b_o` in cycle n+5 while `valid_o` is high, and both channels carry samples from the same cycle.
- R2: With `twos_sel_i` low the bus shows the input code unchanged (offset binary). With it high, bit 9 is inverted, which gives two's complement: input 10'h200 (bipolar zero) gives 10'h000, input 10'h000 (negative full scale) gives 10'h200, and input 10'h3FF gives 10'h1FF. Bits 8..0 are never changed by the format.
- R3: During reset both buses read 0, `valid_o` is 0 and both drive enables are 0. After reset is released, `valid_o` first reads high 6 cycles later.
- R4: When `oe_n_i` is high, both drive enables are low from the next cycle on. When it is low, they are high from the next cycle on. The data path is not affected by this pin.
- R5: While `pd_i` is high, the buses hold the value they had before power-down was entered, input codes are ignored and `valid_o` is low.
- R6: After `pd_i` is released (with `sleep_i` low) in cycle m, `valid_o` stays low and the held value stays on the buses until cycle m+37. That is the 30-cycle wake time plus the 5-sample refill plus 2 register stages. From that cycle on, fresh data follow R1.
- R7: Sleep behaves like power-down, but its wake time is 11 cycles, so valid returns in cycle m+18 after `sleep_i` is released in cycle m.
- R8: With `pd_i` and `sleep_i` both high, power-down governs. Releasing `pd_i` while `sleep_i` stays high moves to sleep, with no wake-up. The later release of `sleep_i` then uses the sleep wake time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_a_i | input | 10 | Corrected code from channel A, offset binary |
| code_b_i | input | 10 | Corrected code from channel B, offset binary |
| twos_sel_i | input | 1 | 1 = two's complement output, 0 = offset binary |
| oe_n_i | input | 1 | 1 = buses released (high impedance), 0 = buses driven |
| pd_i | input | 1 | Full power-down request |
| sleep_i | input | 1 | Sleep request (converters off, bias kept) |
| bus_a_o | output | 10 | Channel A output data |
| bus_b_o | output | 10 | Channel B output data |
| drv_a_o | output | 1 | Channel A bus drive enable |
| drv_b_o | output | 1 | Channel B bus drive enable |
| valid_o | output | 1 | Fresh data present on both buses |

## Verification
The assertions assume that the power-control and format pins are synchronous to the sample clock and are only sampled at rising edges. They also assume the latency is at least two registers, so that the check linking a rising valid to the end of the refill never reaches back into reset. The bench changes every input just after the falling edge and keeps the format pin constant across each power-save episode, so the held value and its format are known. Before each entry into a power-save mode, the bench holds the input code steady for longer than the latency, so the held value does not depend on the exact entry edge.

// File: rtl/aos_pkg.sv
package aos_pkg;

  localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;

  typedef enum logic [2:0] {
    PS_RUN   = 3'd0,
    PS_SLEEP = 3'd1,
    PS_DOWN  = 3'd2,
    PS_WAKE  = 3'd3,
    PS_FILL  = 3'd4
  } pwr_state_e;

  // Round a time in nanoseconds up to whole clock cycles.
  function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                               input longint unsigned hz);
    longint unsigned q;
    q = (ns * hz + NS_PER_SEC - 64'd1) / NS_PER_SEC;
    return q[31:0];
  endfunction

endpackage

// File: rtl/aos_delay_line.sv
module aos_delay_line #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);

  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= din_i;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign dout_o = stg[DEPTH-1];

endmodule

// File: rtl/aos_out_latch.sv
module aos_out_latch #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         twos_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);

  // Offset binary and two's complement differ only in the top bit.
  function automatic logic [W-1:0] to_format(input logic [W-1:0] raw,
                                             input logic         twos);
    logic [W-1:0] r;
    r        = raw;
    r[W-1]   = raw[W-1] ^ twos;
    return r;
  endfunction

  logic [W-1:0] fmt_word;
  assign fmt_word = to_format(din_i, twos_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dout_o <= '0;
    else if (load_i) dout_o <= fmt_word;
  end

  // R5: no load means the bus keeps its value
  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(dout_o));

  // R2: the format never touches the low bits
  assert_low_bits_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> dout_o[W-2:0] == $past(din_i[W-2:0]));

endmodule

// File: rtl/aos_power_ctl.sv
module aos_power_ctl
  import aos_pkg::*;
#(
  parameter int unsigned LAT     = 5,
  parameter int unsigned W_SLEEP = 11,
  parameter int unsigned W_DOWN  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_i,
  input  logic sleep_i,
  output logic load_o,
  output logic valid_o
);

  localparam int unsigned WMAX = (W_DOWN > W_SLEEP) ? W_DOWN : W_SLEEP;
  localparam int unsigned CMAX = (WMAX > LAT) ? WMAX : LAT;
  localparam int unsigned CW   = $clog2(CMAX + 1);

  pwr_state_e    state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          wake_done;
  logic          fill_done;

  assign wake_done = (state == PS_WAKE) && (cnt == '0);
  assign fill_done = (state == PS_FILL) && (cnt == '0);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    if (pd_i) begin
      state_n = PS_DOWN;
    end else if (sleep_i) begin
      state_n = PS_SLEEP;
    end else begin
      unique case (state)
        PS_DOWN: begin
          state_n = PS_WAKE;
          cnt_n   = CW'(W_DOWN - 1);
        end
        PS_SLEEP: begin
          state_n = PS_WAKE;
          cnt_n   = CW'(W_SLEEP - 1);
        end
        PS_WAKE: begin
          if (wake_done) begin
            state_n = PS_FILL;
            cnt_n   = CW'(LAT - 1);
          end else begin
            cnt_n = cnt - 1'b1;
          end
        end
        PS_FILL: begin
          if (fill_done) state_n = PS_RUN;
          else           cnt_n   = cnt - 1'b1;
        end
        default: state_n = PS_RUN;
      endcase
    end
  end

  assign load_o = (state == PS_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PS_FILL;
      cnt     <= CW'(LAT - 1);
      valid_o <= 1'b0;
    end else begin
      state   <= state_n;
      cnt     <= cnt_n;
      valid_o <= load_o;
    end
  end

  // R8: power-down wins over sleep
  assert_pd_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pd_i |=> state == PS_DOWN);

  // R7: sleep alone parks the controller in sleep
  assert_sleep_parks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !pd_i) |=> state == PS_SLEEP);

  // R6: valid only returns once the refill has completed
  assert_fill_before_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(fill_done, 2));

endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage
  import aos_pkg::*;
#(
  parameter int unsigned DW            = 10,
  parameter int unsigned LAT           = 5,
  parameter int unsigned CLK_HZ        = 20_000_000,
  parameter int unsigned SLEEP_WAKE_NS = 510,
  parameter int unsigned DOWN_WAKE_NS  = 1500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] code_a_i,
  input  logic [DW-1:0] code_b_i,
  input  logic          twos_sel_i,
  input  logic          oe_n_i,
  input  logic          pd_i,
  input  logic          sleep_i,
  output logic [DW-1:0] bus_a_o,
  output logic [DW-1:0] bus_b_o,
  output logic          drv_a_o,
  output logic          drv_b_o,
  output logic          valid_o
);

  localparam int unsigned NCH     = 2;
  localparam int unsigned W_SLEEP = ns_to_cycles(SLEEP_WAKE_NS, CLK_HZ);
  localparam int unsigned W_DOWN  = ns_to_cycles(DOWN_WAKE_NS, CLK_HZ);
  localparam int unsigned DEPTH   = LAT - 1;

  logic [DW-1:0] ch_in  [NCH];
  logic [DW-1:0] ch_dly [NCH];
  logic [DW-1:0] ch_out [NCH];
  logic          load_en;
  logic          drv_q;

  assign ch_in[0] = code_a_i;
  assign ch_in[1] = code_b_i;

  aos_power_ctl #(
    .LAT     (LAT),
    .W_SLEEP (W_SLEEP),
    .W_DOWN  (W_DOWN)
  ) u_pwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .pd_i    (pd_i),
    .sleep_i (sleep_i),
    .load_o  (load_en),
    .valid_o (valid_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    aos_delay_line #(
      .W     (DW),
      .DEPTH (DEPTH)
    ) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .din_i  (ch_in[c]),
      .dout_o (ch_dly[c])
    );

    aos_out_latch #(
      .W (DW)
    ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_en),
      .twos_i (twos_sel_i),
      .din_i  (ch_dly[c]),
      .dout_o (ch_out[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= ~oe_n_i;
  end

  assign bus_a_o = ch_out[0];
  assign bus_b_o = ch_out[1];
  assign drv_a_o = drv_q;
  assign drv_b_o = drv_q;

  // R4: a high output-enable pin releases the bus on the next cycle
  assert_oe_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |=> !drv_a_o);

  assert_oe_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_i |=> drv_b_o);

  // R5: nothing on the buses changes while power-down persists
  assert_pd_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pd_i) && pd_i) |=> ($stable(bus_a_o) && $stable(bus_b_o) && !valid_o));

endmodule

// File: tb/tb_adc_out_stage.sv
module tb_adc_out_stage;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 5;
  localparam int WS         = 11;
  localparam int WD         = 30;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] code_a, code_b;
  logic       twos, oe_n, pd, sleep;
  logic [9:0] bus_a, bus_b;
  logic       drv_a, drv_b, valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [9:0] ha [64];
  logic [9:0] hb [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_out_stage dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_a_i   (code_a),
    .code_b_i   (code_b),
    .twos_sel_i (twos),
    .oe_n_i     (oe_n),
    .pd_i       (pd),
    .sleep_i    (sleep),
    .bus_a_o    (bus_a),
    .bus_b_o    (bus_b),
    .drv_a_o    (drv_a),
    .drv_b_o    (drv_b),
    .valid_o    (valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected bus word: signed value (x - 512) written modulo 1024 in two's mode.
  function automatic int conv(input logic [9:0] x);
    if (twos) return (int'(x) + 1024 - 512) % 1024;
    return int'(x);
  endfunction

  function automatic logic [9:0] pat(input int k);
    return 10'((k * 37 + 11) % 1024);
  endfunction

  task automatic step(input logic [9:0] a, input logic [9:0] b);
    code_a = a;
    code_b = b;
    ha[cyc & 63] = a;
    hb[cyc & 63] = b;
    @(negedge clk);
    cyc++;
  endtask

  task automatic run_chk(input logic [9:0] a, input logic [9:0] b, input string req);
    step(a, b);
    chk({req, " valid"}, int'(valid), 1);
    chk({req, " bus_a"}, int'(bus_a), conv(ha[(cyc - LAT) & 63]));
    chk({req, " bus_b"}, int'(bus_b), conv(hb[(cyc - LAT) & 63]));
  endtask

  task automatic wake_count(input string req, input int exp_n,
                            input logic [9:0] held_a, input logic [9:0] held_b);
    int n = 0;
    bit held_ok = 1'b1;
    for (int k = 0; k < 100; k++) begin
      step(pat(cyc), ~pat(cyc));
      n++;
      if (valid) break;
      if (int'(bus_a) != conv(held_a) || int'(bus_b) != conv(held_b)) held_ok = 1'b0;
    end
    chk({req, " wake cycles"}, n, exp_n);
    chk({req, " held during wake"}, int'(held_ok), 1);
    chk({req, " fresh data after wake"}, int'(bus_a), conv(ha[(cyc - LAT) & 63]));
  endtask

  task automatic t_reset;
    int n = 0;
    rst_n = 1'b0; code_a = '0; code_b = '0;
    twos = 1'b0; oe_n = 1'b0; pd = 1'b0; sleep = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 reset bus_a", int'(bus_a), 0);
    chk("R3 reset bus_b", int'(bus_b), 0);
    chk("R3 reset valid", int'(valid), 0);
    chk("R3 reset drive", int'(drv_a | drv_b), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 50; k++) begin
      step(pat(cyc), ~pat(cyc));
      n++;
      if (valid) break;
    end
    chk("R3 valid after reset", n, LAT + 1);
  endtask

  task automatic t_latency;
    twos = 1'b0;
    for (int k = 0; k < 20; k++) run_chk(pat(cyc), 10'(cyc * 5), "R1 latency");
  endtask

  task automatic t_format;
    twos = 1'b0;
    repeat (6) run_chk(10'h200, 10'h3FF, "R2 offset");
    chk("R2 offset zero", int'(bus_a), 'h200);
    twos = 1'b1;
    repeat (6) run_chk(10'h200, 10'h3FF, "R2 twos");
    chk("R2 twos bipolar zero", int'(bus_a), 'h000);
    chk("R2 twos plus full scale", int'(bus_b), 'h1FF);
    repeat (6) run_chk(10'h000, 10'h001, "R2 twos");
    chk("R2 twos minus full scale", int'(bus_a), 'h200);
    for (int k = 0; k < 8; k++) run_chk(pat(cyc), ~pat(cyc), "R2 twos stream");
    twos = 1'b0;
  endtask

  task automatic t_oe;
    oe_n = 1'b1;
    run_chk(pat(cyc), 10'h155, "R4 released");
    chk("R4 drive a off", int'(drv_a), 0);
    chk("R4 drive b off", int'(drv_b), 0);
    run_chk(pat(cyc), 10'h0AA, "R4 data unaffected");
    oe_n = 1'b0;
    run_chk(pat(cyc), 10'h2AA, "R4 driven");
    chk("R4 drive on", int'(drv_a & drv_b), 1);
  endtask

  task automatic t_powerdown;
    bit ok = 1'b1;
    repeat (8) run_chk(10'h155, 10'h2C3, "R5 pre-entry");
    pd = 1'b1;
    step(10'h3F0, 10'h00F);
    for (int k = 0; k < 30; k++) begin
      step(pat(cyc), ~pat(cyc));
      if (valid || int'(bus_a) != conv(10'h155) || int'(bus_b) != conv(10'h2C3)) ok = 1'b0;
    end
    chk("R5 hold and ignore during power-down", int'(ok), 1);
    pd = 1'b0;
    wake_count("R6", WD + LAT + 2, 10'h155, 10'h2C3);
    repeat (4) run_chk(pat(cyc), ~pat(cyc), "R6 after wake");
  endtask

  task automatic t_sleep;
    bit ok = 1'b1;
    twos = 1'b1;
    repeat (8) run_chk(10'h0F3, 10'h301, "R7 pre-entry");
    sleep = 1'b1;
    step(10'h111, 10'h222);
    for (int k = 0; k < 20; k++) begin
      step(pat(cyc), ~pat(cyc));
      if (valid || int'(bus_a) != conv(10'h0F3)) ok = 1'b0;
    end
    chk("R7 hold during sleep", int'(ok), 1);
    sleep = 1'b0;
    wake_count("R7", WS + LAT + 2, 10'h0F3, 10'h301);
    twos = 1'b0;
    repeat (6) run_chk(pat(cyc), ~pat(cyc), "R7 after wake");
  endtask

  task automatic t_both;
    bit ok = 1'b1;
    repeat (8) run_chk(10'h2A5, 10'h05A, "R8 pre-entry");
    pd = 1'b1; sleep = 1'b1;
    step(10'h3FF, 10'h3FF);
    repeat (10) step(pat(cyc), ~pat(cyc));
    pd = 1'b0;
    for (int k = 0; k < 45; k++) begin
      step(pat(cyc), ~pat(cyc));
      if (valid || int'(bus_a) != conv(10'h2A5)) ok = 1'b0;
    end
    chk("R8 stays asleep after power-down release", int'(ok), 1);
    sleep = 1'b0;
    wake_count("R8", WS + LAT + 2, 10'h2A5, 10'h05A);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_format();
    t_oe();
    t_powerdown();
    t_sleep();
    t_both();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule